// File: doc/BRIEF.md
# Hashed Four-Byte Match Finder

The block searches a byte stream for a 4-byte sequence that has already appeared earlier in the stream. It steps through the stream one byte position at a time and takes a 32-bit window at each position. A multiplicative hash of the window selects one row of a direct-mapped table. Each row stores three things: the 32-bit window last seen there, the stream position where it was seen, and a valid flag. A match is found when the selected row is valid and its stored word equals the current window. The block then reports the current position and the stored position as a pair, and it stops scanning.

A controller starts a job through a start handshake. The start carries a first position, an end position (exclusive) and a flag that marks a new job. A new job flash-clears every valid flag. A restart that does not set the flag keeps the table, so scanning can resume after a match. The block shows on `win_pos` the position whose window it wants next and takes that window over a ready/valid handshake. If the scan reaches the end position without a hit, the block raises `done`.

Top module: `quad_match_finder`

## Requirements
- R1: After reset, `start_ready` is 1 and `win_ready`, `m_valid` and `done` are 0.
- R2: The row index is the upper log2(ROWS) bits of the low 32 bits of the product of the window and 0x1e35a7bd. With the default ROWS = 512 this is product bits [31:23].
- R3: When an accepted window selects a valid row whose stored word equals the window, `m_valid` rises on the next cycle. `m_cur` then equals the window's position and `m_prev` equals the position stored in that row.
- R4: Every accepted window overwrites its row with its own word and position and sets the row's valid flag, including the window that causes a match. A later match therefore reports the most recent earlier position that was written to that row.
- R5: A window whose row is valid but holds a different word produces no match. It replaces the row's contents.
- R6: A start with `start_clear` = 1 clears all valid flags. In the cycle after that start is accepted, `start_ready` and `win_ready` are both 0. After the clear, no window seen before the clear can cause a match.
- R7: A start with `start_clear` = 0 keeps the table contents, so windows written before the restart can still match.
- R8: An accepted start loads `win_pos` with `start_pos`. Each accepted window that does not match advances `win_pos` by one.
- R9: While `m_valid` is 1, `win_ready` and `start_ready` are 0, and `m_cur` and `m_prev` stay stable until `m_ready`. After the handshake, `m_valid` falls and `start_ready` is 1, and no window is taken until a new start.
- R10: When `win_pos` reaches `start_end` without a match, `done` goes to 1, `win_ready` stays 0, and `done` holds until the next start is accepted. A start with `start_pos` ≥ `start_end` ends in `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_valid | input | 1 | Start request valid |
| start_ready | output | 1 | Block can accept a start |
| start_clear | input | 1 | Start opens a new job and clears the table |
| start_pos | input | POS_W | First position to scan |
| start_end | input | POS_W | Position at which the scan stops (exclusive) |
| win_valid | input | 1 | Window for `win_pos` is present |
| win_ready | output | 1 | Block takes a window this cycle |
| win_pos | output | POS_W | Position whose window is wanted |
| win_data | input | 32 | Four stream bytes starting at `win_pos` |
| m_valid | output | 1 | Match pair is valid |
| m_ready | input | 1 | Consumer takes the match pair |
| m_cur | output | POS_W | Position of the matching window |
| m_prev | output | POS_W | Earlier position holding the same word |
| done | output | 1 | Scan reached its end without a match |

## Verification
Two functions share one cycle at each accepted window: the table row is read for the comparison and overwritten with the new window. The compare must use the row's old contents. This is provoked with repeating patterns, where a window hits the row it is about to replace. It is also provoked with a bench-searched pair of different words that share a row, so a valid row holds the wrong word. In every case the reported positions are judged against a bench model that reads before it writes. A restart with and without the clear flag over windows already in the table checks that the flash clear, not the stale contents, decides the first compare.

// File: rtl/qmf_pkg.sv
package qmf_pkg;
    localparam logic [31:0] HASH_MULT = 32'h1e35a7bd;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CLEAR = 3'd1,
        ST_SCAN  = 3'd2,
        ST_MATCH = 3'd3,
        ST_DONE  = 3'd4
    } qmf_state_e;
endpackage

// File: rtl/qmf_hash.sv
module qmf_hash #(
    parameter int IDX_W = 9
) (
    input  logic [31:0]      word_i,
    output logic [IDX_W-1:0] idx_o
);
    logic [31:0] prod;

    always_comb begin
        prod  = word_i * qmf_pkg::HASH_MULT;
        idx_o = IDX_W'(prod >> (32 - IDX_W));
    end
endmodule

// File: rtl/qmf_table.sv
module qmf_table #(
    parameter int ROWS  = 512,
    parameter int POS_W = 16,
    localparam int IDX_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             wr_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [31:0]      word_i,
    input  logic [POS_W-1:0] pos_i,
    output logic             hit_o,
    output logic [POS_W-1:0] hit_pos_o
);
    typedef struct packed {
        logic [ROWS-1:0] vld;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    logic [31:0]      word_mem [ROWS];
    logic [POS_W-1:0] pos_mem  [ROWS];

    // Read-before-write: compare uses the row as it was before this cycle
    always_comb begin
        hit_o     = tbl_q.vld[idx_i] && (word_mem[idx_i] == word_i);
        hit_pos_o = pos_mem[idx_i];
    end

    always_comb begin
        tbl_d = tbl_q;
        if (clr_i) begin
            tbl_d.vld = '0;
        end else if (wr_i) begin
            tbl_d.vld[idx_i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    always_ff @(posedge clk) begin
        if (wr_i) begin
            word_mem[idx_i] <= word_i;
            pos_mem[idx_i]  <= pos_i;
        end
    end

    // R6: a flash clear leaves no row able to hit on the next cycle
    a_r6_no_hit_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !hit_o);
endmodule

// File: rtl/quad_match_finder.sv
module quad_match_finder #(
    parameter int ROWS  = 512,
    parameter int POS_W = 16,
    localparam int IDX_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_valid,
    output logic             start_ready,
    input  logic             start_clear,
    input  logic [POS_W-1:0] start_pos,
    input  logic [POS_W-1:0] start_end,
    input  logic             win_valid,
    output logic             win_ready,
    output logic [POS_W-1:0] win_pos,
    input  logic [31:0]      win_data,
    output logic             m_valid,
    input  logic             m_ready,
    output logic [POS_W-1:0] m_cur,
    output logic [POS_W-1:0] m_prev,
    output logic             done
);
    import qmf_pkg::*;

    typedef struct packed {
        qmf_state_e       st;
        logic [POS_W-1:0] pos;
        logic [POS_W-1:0] lim;
        logic [POS_W-1:0] cur;
        logic [POS_W-1:0] prev;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             win_fire;
    logic             tbl_clr;
    logic [IDX_W-1:0] row_idx;
    logic             tbl_hit;
    logic [POS_W-1:0] tbl_pos;

    qmf_hash #(.IDX_W(IDX_W)) u_hash (
        .word_i (win_data),
        .idx_o  (row_idx)
    );

    qmf_table #(.ROWS(ROWS), .POS_W(POS_W)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (tbl_clr),
        .wr_i      (win_fire),
        .idx_i     (row_idx),
        .word_i    (win_data),
        .pos_i     (ctl_q.pos),
        .hit_o     (tbl_hit),
        .hit_pos_o (tbl_pos)
    );

    always_comb begin
        ctl_d       = ctl_q;
        start_ready = (ctl_q.st == ST_IDLE) || (ctl_q.st == ST_DONE);
        win_ready   = (ctl_q.st == ST_SCAN) && (ctl_q.pos < ctl_q.lim);
        win_fire    = win_ready && win_valid;
        tbl_clr     = (ctl_q.st == ST_CLEAR);

        unique case (ctl_q.st)
            ST_IDLE, ST_DONE: begin
                if (start_valid) begin
                    ctl_d.pos = start_pos;
                    ctl_d.lim = start_end;
                    ctl_d.st  = start_clear ? ST_CLEAR : ST_SCAN;
                end
            end
            ST_CLEAR: ctl_d.st = ST_SCAN;
            ST_SCAN: begin
                if (ctl_q.pos >= ctl_q.lim) begin
                    ctl_d.st = ST_DONE;
                end else if (win_fire) begin
                    if (tbl_hit) begin
                        ctl_d.st   = ST_MATCH;
                        ctl_d.cur  = ctl_q.pos;
                        ctl_d.prev = tbl_pos;
                    end else begin
                        ctl_d.pos = ctl_q.pos + 1'b1;
                    end
                end
            end
            ST_MATCH: if (m_ready) ctl_d.st = ST_IDLE;
            default:  ctl_d.st = ST_IDLE;
        endcase

        win_pos = ctl_q.pos;
        m_valid = (ctl_q.st == ST_MATCH);
        m_cur   = ctl_q.cur;
        m_prev  = ctl_q.prev;
        done    = (ctl_q.st == ST_DONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // R3: a table hit on an accepted window surfaces as a match at that position
    a_r3_hit_reported: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid && win_ready && tbl_hit) |=> (m_valid && m_cur == $past(win_pos)));

    // R8: a non-matching window advances the scan position by one
    a_r8_pos_step: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid && win_ready && !tbl_hit) |=> (win_pos == $past(win_pos) + 1'b1));

    // R6: one quiet cycle after a start that opens a new job
    a_r6_clear_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (start_valid && start_ready && start_clear) |=> (!win_ready && !start_ready));

    // R9: pair held while the consumer stalls
    a_r9_match_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_cur) && $stable(m_prev)));

    // R9: nothing scanned or started while a pair is pending
    a_r9_paused: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid |-> (!win_ready && !start_ready));

    // R10: done excludes scanning and matching
    a_r10_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!win_ready && !m_valid));
endmodule

// File: tb/tb_quad_match_finder.sv
`timescale 1ns/1ps
module tb_quad_match_finder;
    localparam int ROWS  = 512;
    localparam int POS_W = 16;
    localparam int SLEN  = 8192;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_valid = 1'b0;
    logic             start_ready;
    logic             start_clear = 1'b0;
    logic [POS_W-1:0] start_pos = '0;
    logic [POS_W-1:0] start_end = '0;
    logic             win_valid = 1'b0;
    logic             win_ready;
    logic [POS_W-1:0] win_pos;
    logic [31:0]      win_data = '0;
    logic             m_valid;
    logic             m_ready = 1'b0;
    logic [POS_W-1:0] m_cur;
    logic [POS_W-1:0] m_prev;
    logic             done;

    int n_checks = 0;
    int n_fails  = 0;
    int drop_pct = 25;

    logic [7:0]  stream [SLEN];
    logic        mvld  [ROWS];
    logic [31:0] mword [ROWS];
    int          mpos  [ROWS];

    always #2 clk = ~clk;

    quad_match_finder #(.ROWS(ROWS), .POS_W(POS_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .start_valid(start_valid), .start_ready(start_ready), .start_clear(start_clear),
        .start_pos(start_pos), .start_end(start_end),
        .win_valid(win_valid), .win_ready(win_ready), .win_pos(win_pos), .win_data(win_data),
        .m_valid(m_valid), .m_ready(m_ready), .m_cur(m_cur), .m_prev(m_prev), .done(done)
    );

    function automatic logic [31:0] bwin(int p);
        return {stream[(p+3)%SLEN], stream[(p+2)%SLEN], stream[(p+1)%SLEN], stream[p%SLEN]};
    endfunction

    function automatic int bhash(logic [31:0] w);
        logic [31:0] pr;
        pr = w * 32'h1e35a7bd;
        return int'(pr[31:23]);
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    task automatic chk(bit ok, string req, longint act, longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // window driver
    initial begin
        forever begin
            @(negedge clk);
            win_valid = ($urandom_range(0, 99) >= drop_pct);
            win_data  = bwin(int'(win_pos));
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

    // reference model: returns 1 on match with cur/prev
    function automatic bit model_job(bit clr, int sp, int ep, output int cur, output int prev);
        if (clr) for (int i = 0; i < ROWS; i++) mvld[i] = 1'b0;
        for (int p = sp; p < ep; p++) begin
            logic [31:0] w;
            int h;
            bit hit;
            w = bwin(p);
            h = bhash(w);
            hit = mvld[h] && (mword[h] == w);
            prev = mpos[h];
            mvld[h] = 1'b1; mword[h] = w; mpos[h] = p;
            if (hit) begin
                cur = p;
                return 1'b1;
            end
        end
        return 1'b0;
    endfunction

    task automatic do_start(bit clr, int sp, int ep);
        @(negedge clk);
        while (!start_ready) @(negedge clk);
        start_valid = 1'b1; start_clear = clr;
        start_pos = POS_W'(sp); start_end = POS_W'(ep);
        @(negedge clk);
        start_valid = 1'b0;
        chk(win_pos == POS_W'(sp), "R8 start loads position", win_pos, sp);
        if (clr) chk(!start_ready && !win_ready, "R6 clear cycle quiet",
                     {start_ready, win_ready}, 0);
    endtask

    task automatic run_job(bit clr, int sp, int ep, string req);
        int ecur, eprev, n;
        bit emat;
        emat = model_job(clr, sp, ep, ecur, eprev);
        do_start(clr, sp, ep);
        n = 0;
        while (!m_valid && !done && n < 20000) begin
            @(negedge clk);
            n++;
        end
        if (emat) begin
            chk(m_valid, {req, " match raised"}, m_valid, 1);
            chk(m_cur == POS_W'(ecur), {req, " m_cur"}, m_cur, ecur);
            chk(m_prev == POS_W'(eprev), {req, " m_prev"}, m_prev, eprev);
            repeat (2) begin
                @(negedge clk);
                chk(m_valid && m_cur == POS_W'(ecur) && m_prev == POS_W'(eprev) && !win_ready,
                    "R9 hold while stalled", m_cur, ecur);
            end
            m_ready = 1'b1;
            @(negedge clk);
            m_ready = 1'b0;
            chk(!m_valid && start_ready && !win_ready, "R9 released after handshake",
                {m_valid, start_ready, win_ready}, 3'b010);
        end else begin
            chk(done && !m_valid, {req, " R10 done raised"}, {done, m_valid}, 2'b10);
            chk(!win_ready, "R10 no window taken after end", win_ready, 0);
            @(negedge clk);
            chk(done, "R10 done held", done, 1);
        end
    endtask

    initial begin
        logic [31:0] w1, w2;
        int pc, cl;
        void'($urandom(32'd4242));
        for (int i = 0; i < SLEN; i++) stream[i] = 8'($urandom_range(0, 2) + 8'h41);
        for (int i = 0; i < ROWS; i++) begin mvld[i] = 0; mword[i] = 0; mpos[i] = 0; end
        // period-4 pattern
        for (int i = 0; i < 64; i++) stream[i] = 8'h61 + 8'(i % 4);
        // incrementing bytes: every window distinct
        for (int i = 200; i < 460; i++) stream[i] = 8'(i - 200);
        // collision pair: different words, same row
        w1 = 32'h11223344;
        w2 = w1;
        for (int k = 1; k < 1000000; k++) begin
            if (bhash(w1 + 32'(k)) == bhash(w1)) begin w2 = w1 + 32'(k); break; end
        end
        for (int b = 0; b < 4; b++) begin
            stream[100 + b] = w1[8*b +: 8];
            stream[104 + b] = w2[8*b +: 8];
            stream[108 + b] = w2[8*b +: 8];
        end

        repeat (3) @(negedge clk);
        chk(start_ready && !win_ready && !m_valid && !done, "R1 reset state",
            {start_ready, win_ready, m_valid, done}, 4'b1000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(start_ready && !win_ready && !m_valid && !done, "R1 after reset release",
            {start_ready, win_ready, m_valid, done}, 4'b1000);

        run_job(1'b1, 0, 40, "R3 R4 repeating pattern");
        run_job(1'b0, 5, 40, "R7 restart keeps table");
        chk(w2 != w1 && bhash(w2) == bhash(w1), "R2 collision pair found", w2, w1);
        run_job(1'b1, 100, 112, "R5 R2 collision rejected");
        run_job(1'b1, 200, 300, "R10 distinct windows");
        run_job(1'b0, 200, 300, "R7 rescan of known windows");
        run_job(1'b1, 200, 300, "R6 clear forgets windows");
        run_job(1'b1, 50, 50, "R10 empty range");
        run_job(1'b0, 60, 10, "R10 inverted range");
        drop_pct = 0;
        run_job(1'b1, 0, 12, "R3 full-rate pattern");
        for (int it = 0; it < 30; it++) begin
            drop_pct = $urandom_range(0, 60);
            pc = $urandom_range(1000, 7800);
            cl = $urandom_range(0, 1);
            run_job(cl[0], pc, pc + $urandom_range(0, 300), "R3 R4 random stream");
        end
        summary();
        $finish;
    end
endmodule